// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Handshake Timeout

This block sits behind the byte-addressed register window of a parallel port and turns host accesses to two transfer registers into address or data byte cycles on the port's enhanced-mode pins. Each cycle is allowed only when the control register holds one exact pattern for the direction of the cycle. A cycle that is not allowed is dropped without any pin activity, and a read that is not allowed returns all ones. Wide 16-bit and 32-bit accesses to the data transfer register are split into byte cycles, least significant byte first.

Each byte cycle sets the write line and data, lowers the address strobe or the data strobe, and holds it until the peripheral raises its wait response. A parameterised cycle counter bounds that wait. When the limit is reached, a sticky timeout flag is set and the rest of the access is abandoned. The flag shows in bit 0 of the status register, and a status write with bit 0 set clears it. Writes to the data latch and the control register that would not change the stored value are suppressed. Writes that do change them raise update pulses to the pin driver, and a change of direction gets a pulse of its own one cycle ahead of the control update.

Top module: `epp_port_engine`

## Requirements
- R1: After reset the control register reads 0xCC, the data latch reads 0xFF, status bit 0 reads 0 and no strobe is driven. Register reads return the 8-bit value in bits 7:0 with every higher bit of host_rdata set to one.
- R2: A write to offset 0 whose byte differs from the latch stores it and gives exactly one upd_data_vld pulse carrying the byte. An equal byte gives no pulse.
- R3: A write to offset 2 stores the byte with bits 7:6 forced to one. If the forced value equals the stored one nothing is issued. Otherwise one upd_ctl_vld pulse carries bits 4:0, with no direction pulse when bit 5 is unchanged.
- R4: A control write that changes bit 5 (1 = input direction) first gives one upd_dir_vld pulse with the new bit 5, and upd_ctl_vld follows in the next cycle.
- R5: A write to offset 3 (address transfer) or offset 4 (data transfer) runs cycles only if (control & 0x2F) == 0x04. Offset 3 lowers epp_astb_n and offset 4 lowers epp_dstb_n, each with epp_nwrite low and the byte on epp_dout.
- R6: A read of offset 3 or 4 runs cycles only if (control & 0x2F) == 0x24, with epp_nwrite high, and returns the bytes sampled from epp_din.
- R7: A transfer write that is not allowed causes no strobe. A transfer read that is not allowed returns 0xFFFFFFFF. Control bits 4, 6 and 7 play no part in the check.
- R8: At offset 4, host_size 0 moves one byte, 1 moves two and 2 or 3 moves four, least significant byte first. Offset 3 always moves one byte. Read bytes that are not moved read as 0xFF.
- R9: A strobe held for TMO_CYCLES cycles without epp_wait ends the cycle, sets the timeout flag and abandons the remaining bytes.
- R10: The timeout flag stays set until a write to offset 1 with bit 0 set. A status read returns pin_stat in bits 7:1 and the flag in bit 0.
- R11: Only one strobe is low at a time. While a strobe is low, epp_dout and epp_nwrite stay stable, and the strobe is released one cycle after epp_wait is seen.
- R12: host_rdy is high only when idle. Each accepted access gives exactly one host_done pulse, with host_rdata valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, taken when host_rdy is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Access width code for offset 4 |
| host_wdata | input | HOST_W | Write data |
| host_rdy | output | 1 | Engine idle, can accept a request |
| host_done | output | 1 | Access complete pulse |
| host_rdata | output | HOST_W | Read data, valid with host_done |
| pin_stat | input | 7 | Peripheral status lines shown in status bits 7:1 |
| upd_data_vld | output | 1 | Data latch update pulse |
| upd_data | output | 8 | New data latch value |
| upd_dir_vld | output | 1 | Direction change pulse |
| upd_dir | output | 1 | New direction, 1 = input |
| upd_ctl_vld | output | 1 | Control line update pulse |
| upd_ctl | output | 5 | New control bits 4:0 |
| epp_nwrite | output | 1 | Write line, low for a write cycle |
| epp_astb_n | output | 1 | Address strobe, active low |
| epp_dstb_n | output | 1 | Data strobe, active low |
| epp_dout | output | 8 | Byte driven during a write cycle |
| epp_din | input | 8 | Byte returned by the peripheral |
| epp_wait | input | 1 | Peripheral handshake response, high = done |

## Verification
The assertions assume that the host raises host_req only while host_rdy is high and holds it for one cycle. They also assume that the peripheral drops epp_wait once the strobe is released and keeps epp_din steady while a strobe is low. The bench host task drives one request at a time and waits for host_done before the next. The peripheral model raises epp_wait a programmed number of cycles after a strobe falls, or never, clears it as soon as the strobe rises, and can be told to go silent after a given number of bytes so that timeouts land in the middle of a wide access.

// File: rtl/epp_pkg.sv
// Package: shared offsets, control patterns and state types for the
// enhanced parallel port cycle gate. Assumes byte-wide pin data.
package epp_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;
    localparam logic [2:0] OFF_EADR = 3'd3;
    localparam logic [2:0] OFF_EDAT = 3'd4;

    localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
    localparam logic [7:0] CTL_WR_PAT    = 8'h04;
    localparam logic [7:0] CTL_RD_PAT    = 8'h24;
    localparam logic [7:0] CTL_FIXED     = 8'hC0;
    localparam logic [7:0] CTL_RESET     = 8'hCC;
    localparam int         CTL_DIR_BIT   = 5;

    typedef enum logic [1:0] {BC_IDLE, BC_SETUP, BC_STROBE, BC_END} bc_state_e;
    typedef enum logic [2:0] {AS_IDLE, AS_DIR, AS_DONE, AS_LAUNCH, AS_WAIT} as_state_e;
endpackage

// File: rtl/epp_ctl_regs.sv
// Module: storage for the data latch, the control register and the sticky
// timeout flag. Assumes the sequencer never sets and clears the flag at once.
module epp_ctl_regs
    import epp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_wv,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] ctl_wv,
    input  logic              tmo_set,
    input  logic              tmo_clr,
    output logic [BYTE_W-1:0] dataw,
    output logic [BYTE_W-1:0] ctl,
    output logic              tmo
);
    // Purpose: hold latch, control (top bits forced) and timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dataw <= '1;
            ctl   <= CTL_RESET;
            tmo   <= 1'b0;
        end else begin
            if (data_we) dataw <= data_wv;
            if (ctl_we)  ctl   <= ctl_wv | CTL_FIXED;
            if (tmo_set)      tmo <= 1'b1;
            else if (tmo_clr) tmo <= 1'b0;
        end
    end

    // R10: a failed cycle and a clearing status write never coincide
    a_r10_set_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmo_set && tmo_clr));
endmodule

// File: rtl/epp_byte_cycle.sv
// Module: one address or data byte cycle on the enhanced port pins.
// Sets write line and data, lowers the selected strobe, waits for the
// peripheral response or the timeout limit, then releases the strobe.
// Assumes start is only pulsed while the engine is idle.
module epp_byte_cycle
    import epp_pkg::*;
#(
    parameter int TMO_CYCLES = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic              adr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              wait_in,
    input  logic [BYTE_W-1:0] din,
    output logic              nwrite,
    output logic              astb_n,
    output logic              dstb_n,
    output logic [BYTE_W-1:0] dout,
    output logic              fin,
    output logic              fail,
    output logic [BYTE_W-1:0] rbyte
);
    localparam int CW = $clog2(TMO_CYCLES + 1) + 1;

    bc_state_e         st;
    logic              rd_q, adr_q, fail_q;
    logic [BYTE_W-1:0] dout_q;
    logic [CW-1:0]     cnt;

    // Purpose: byte cycle state machine with bounded strobe wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BC_IDLE;
            rd_q   <= 1'b1;
            adr_q  <= 1'b0;
            fail_q <= 1'b0;
            dout_q <= '0;
            rbyte  <= '1;
            cnt    <= '0;
        end else begin
            unique case (st)
                BC_IDLE: if (start) begin
                    st     <= BC_SETUP;
                    rd_q   <= rd;
                    adr_q  <= adr;
                    dout_q <= wbyte;
                    cnt    <= '0;
                    fail_q <= 1'b0;
                end
                BC_SETUP: st <= BC_STROBE;
                BC_STROBE: begin
                    if (wait_in) begin
                        rbyte  <= din;
                        fail_q <= 1'b0;
                        st     <= BC_END;
                    end else if (cnt == CW'(TMO_CYCLES - 1)) begin
                        fail_q <= 1'b1;
                        st     <= BC_END;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                BC_END: st <= BC_IDLE;
                default: st <= BC_IDLE;
            endcase
        end
    end

    // Purpose: pin drive derived from the cycle phase.
    always_comb begin
        nwrite = !((st == BC_SETUP || st == BC_STROBE) && !rd_q);
        astb_n = !(st == BC_STROBE && adr_q);
        dstb_n = !(st == BC_STROBE && !adr_q);
        dout   = dout_q;
        fin    = (st == BC_END);
        fail   = fail_q;
    end

    // Purpose: checker counter of strobe-low cycles with no response.
    logic [CW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                           low_run <= '0;
        else if ((!astb_n || !dstb_n) && !wait_in) low_run <= low_run + 1'b1;
        else                                  low_run <= '0;
    end

    // R11: never both strobes low
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!astb_n && !dstb_n));
    // R11: pins steady while a strobe stays low
    a_r11_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((!astb_n || !dstb_n) && $past(!astb_n || !dstb_n)) |-> ($stable(dout) && $stable(nwrite)));
    // R9: unanswered strobe never outlasts the limit
    a_r9_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= CW'(TMO_CYCLES));
endmodule

// File: rtl/epp_access_seq.sv
// Module: host access sequencer. Decodes offsets, gates transfer cycles on
// the control pattern, splits wide transfers into bytes (LSB first), issues
// pin update pulses and raises the timeout flag. Assumes host_req only when
// host_rdy is high.
module epp_access_seq
    import epp_pkg::*;
#(
    parameter int HOST_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_rdy,
    output logic              host_done,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [6:0]        pin_stat,
    input  logic [BYTE_W-1:0] dataw,
    input  logic [BYTE_W-1:0] ctl,
    input  logic              tmo,
    output logic              data_we,
    output logic [BYTE_W-1:0] data_wv,
    output logic              ctl_we,
    output logic [BYTE_W-1:0] ctl_wv,
    output logic              tmo_set,
    output logic              tmo_clr,
    output logic              upd_data_vld,
    output logic [BYTE_W-1:0] upd_data,
    output logic              upd_dir_vld,
    output logic              upd_dir,
    output logic              upd_ctl_vld,
    output logic [4:0]        upd_ctl,
    output logic              eng_start,
    output logic              eng_rd,
    output logic              eng_adr,
    output logic [BYTE_W-1:0] eng_wbyte,
    input  logic              eng_fin,
    input  logic              eng_fail,
    input  logic [BYTE_W-1:0] eng_rbyte
);
    localparam int NB    = HOST_W / BYTE_W;
    localparam int IW    = (NB > 1) ? $clog2(NB) : 1;
    localparam int LW    = $clog2(NB + 1);
    localparam int MAXSZ = $clog2(NB);

    as_state_e         st;
    logic [HOST_W-1:0] shreg, rbuf;
    logic [LW-1:0]     left, req_nb;
    logic [IW-1:0]     idx;
    logic              k_rd, k_adr;
    logic              perm_wr, perm_rd, accept;
    logic [BYTE_W-1:0] ctl_nv;

    // Purpose: permission patterns, byte count and write-side decode.
    always_comb begin
        perm_wr = (ctl & CTL_GATE_MASK) == CTL_WR_PAT;
        perm_rd = (ctl & CTL_GATE_MASK) == CTL_RD_PAT;
        accept  = host_req && (st == AS_IDLE);
        ctl_nv  = host_wdata[BYTE_W-1:0] | CTL_FIXED;
        if (host_addr != OFF_EDAT)            req_nb = LW'(1);
        else if (int'(host_size) >= MAXSZ)    req_nb = LW'(NB);
        else                                  req_nb = LW'(1) << host_size;
        data_we   = accept && host_wr && host_addr == OFF_DATA && host_wdata[BYTE_W-1:0] != dataw;
        data_wv   = host_wdata[BYTE_W-1:0];
        ctl_we    = accept && host_wr && host_addr == OFF_CTRL && ctl_nv != ctl;
        ctl_wv    = ctl_nv;
        tmo_clr   = accept && host_wr && host_addr == OFF_STAT && host_wdata[0];
        tmo_set   = (st == AS_WAIT) && eng_fin && eng_fail;
        eng_start = (st == AS_LAUNCH);
        eng_rd    = k_rd;
        eng_adr   = k_adr;
        eng_wbyte = shreg[BYTE_W-1:0];
        host_rdy  = (st == AS_IDLE);
        host_done = (st == AS_DONE);
        host_rdata = rbuf;
    end

    // Purpose: access state machine, read assembly and update pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= AS_IDLE;
            shreg        <= '0;
            rbuf         <= '1;
            left         <= '0;
            idx          <= '0;
            k_rd         <= 1'b0;
            k_adr        <= 1'b0;
            upd_data_vld <= 1'b0;
            upd_data     <= '0;
            upd_dir_vld  <= 1'b0;
            upd_dir      <= 1'b0;
            upd_ctl_vld  <= 1'b0;
            upd_ctl      <= '0;
        end else begin
            upd_data_vld <= 1'b0;
            upd_dir_vld  <= 1'b0;
            upd_ctl_vld  <= 1'b0;
            unique case (st)
                AS_IDLE: if (host_req) begin
                    rbuf  <= '1;
                    shreg <= host_wdata;
                    left  <= req_nb;
                    idx   <= '0;
                    k_rd  <= !host_wr;
                    k_adr <= (host_addr == OFF_EADR);
                    st    <= AS_DONE;
                    if (host_wr) begin
                        case (host_addr)
                            OFF_DATA: if (host_wdata[BYTE_W-1:0] != dataw) begin
                                upd_data_vld <= 1'b1;
                                upd_data     <= host_wdata[BYTE_W-1:0];
                            end
                            OFF_CTRL: if (ctl_nv != ctl) begin
                                if (ctl_nv[CTL_DIR_BIT] != ctl[CTL_DIR_BIT]) begin
                                    upd_dir_vld <= 1'b1;
                                    upd_dir     <= ctl_nv[CTL_DIR_BIT];
                                    st          <= AS_DIR;
                                end else begin
                                    upd_ctl_vld <= 1'b1;
                                    upd_ctl     <= ctl_nv[4:0];
                                end
                            end
                            OFF_EADR, OFF_EDAT: if (perm_wr) st <= AS_LAUNCH;
                            default: ;
                        endcase
                    end else begin
                        case (host_addr)
                            OFF_DATA: rbuf[BYTE_W-1:0] <= dataw;
                            OFF_STAT: rbuf[BYTE_W-1:0] <= {pin_stat, tmo};
                            OFF_CTRL: rbuf[BYTE_W-1:0] <= ctl;
                            OFF_EADR, OFF_EDAT: if (perm_rd) st <= AS_LAUNCH;
                            default: ;
                        endcase
                    end
                end
                AS_DIR: begin
                    upd_ctl_vld <= 1'b1;
                    upd_ctl     <= ctl[4:0];
                    st          <= AS_DONE;
                end
                AS_LAUNCH: st <= AS_WAIT;
                AS_WAIT: if (eng_fin) begin
                    if (eng_fail) begin
                        st <= AS_DONE;
                    end else begin
                        if (k_rd) rbuf[{idx, 3'b000} +: BYTE_W] <= eng_rbyte;
                        idx   <= idx + 1'b1;
                        shreg <= shreg >> BYTE_W;
                        left  <= left - 1'b1;
                        st    <= (left == LW'(1)) ? AS_DONE : AS_LAUNCH;
                    end
                end
                AS_DONE: st <= AS_IDLE;
                default: st <= AS_IDLE;
            endcase
        end
    end

    // R7: a byte cycle is launched only under the exact control pattern
    a_r7_gate_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == AS_LAUNCH) |-> ((ctl & CTL_GATE_MASK) == (k_rd ? CTL_RD_PAT : CTL_WR_PAT)));
    // R12: no request is presented while busy
    a_r12_req_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> host_rdy);
endmodule

// File: rtl/epp_port_engine.sv
// Module: top of the enhanced parallel port cycle gate. Connects register
// storage, the host access sequencer and the byte cycle engine.
// Assumes one outstanding host access at a time.
module epp_port_engine
    import epp_pkg::*;
#(
    parameter int HOST_W     = 32,
    parameter int TMO_CYCLES = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_rdy,
    output logic              host_done,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [6:0]        pin_stat,
    output logic              upd_data_vld,
    output logic [7:0]        upd_data,
    output logic              upd_dir_vld,
    output logic              upd_dir,
    output logic              upd_ctl_vld,
    output logic [4:0]        upd_ctl,
    output logic              epp_nwrite,
    output logic              epp_astb_n,
    output logic              epp_dstb_n,
    output logic [7:0]        epp_dout,
    input  logic [7:0]        epp_din,
    input  logic              epp_wait
);
    logic [BYTE_W-1:0] dataw, ctl, data_wv, ctl_wv, eng_wbyte, eng_rbyte;
    logic data_we, ctl_we, tmo_set, tmo_clr, tmo;
    logic eng_start, eng_rd, eng_adr, eng_fin, eng_fail;

    epp_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .data_we(data_we), .data_wv(data_wv),
        .ctl_we(ctl_we), .ctl_wv(ctl_wv),
        .tmo_set(tmo_set), .tmo_clr(tmo_clr),
        .dataw(dataw), .ctl(ctl), .tmo(tmo)
    );

    epp_access_seq #(.HOST_W(HOST_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_rdy(host_rdy), .host_done(host_done), .host_rdata(host_rdata),
        .pin_stat(pin_stat), .dataw(dataw), .ctl(ctl), .tmo(tmo),
        .data_we(data_we), .data_wv(data_wv), .ctl_we(ctl_we), .ctl_wv(ctl_wv),
        .tmo_set(tmo_set), .tmo_clr(tmo_clr),
        .upd_data_vld(upd_data_vld), .upd_data(upd_data),
        .upd_dir_vld(upd_dir_vld), .upd_dir(upd_dir),
        .upd_ctl_vld(upd_ctl_vld), .upd_ctl(upd_ctl),
        .eng_start(eng_start), .eng_rd(eng_rd), .eng_adr(eng_adr),
        .eng_wbyte(eng_wbyte), .eng_fin(eng_fin), .eng_fail(eng_fail),
        .eng_rbyte(eng_rbyte)
    );

    epp_byte_cycle #(.TMO_CYCLES(TMO_CYCLES)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .rd(eng_rd), .adr(eng_adr), .wbyte(eng_wbyte),
        .wait_in(epp_wait), .din(epp_din),
        .nwrite(epp_nwrite), .astb_n(epp_astb_n), .dstb_n(epp_dstb_n),
        .dout(epp_dout), .fin(eng_fin), .fail(eng_fail), .rbyte(eng_rbyte)
    );

    // R4: direction pulse is followed by the control pulse next cycle
    a_r4_dir_then_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dir_vld |=> upd_ctl_vld);
    // R2: a data pulse always reports a real change of the stored latch
    a_r2_data_pulse_changes: assert property (@(posedge clk) disable iff (!rst_n)
        upd_data_vld |-> (dataw == upd_data && dataw != $past(dataw)));
    // R10: the flag rises only after a failed byte cycle
    a_r10_tmo_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo) |-> $past(eng_fin && eng_fail));
endmodule

// File: tb/sim_epp_port_engine.sv
module sim_epp_port_engine;
    localparam int TMO = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [1:0] host_size = '0;
    logic [31:0] host_wdata = '0;
    logic host_rdy, host_done;
    logic [31:0] host_rdata;
    logic [6:0] pin_stat = 7'h55;
    logic upd_data_vld, upd_dir_vld, upd_dir, upd_ctl_vld;
    logic [7:0] upd_data;
    logic [4:0] upd_ctl;
    logic epp_nwrite, epp_astb_n, epp_dstb_n;
    logic [7:0] epp_dout, epp_din;
    logic epp_wait = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    epp_port_engine #(.HOST_W(32), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdy(host_rdy), .host_done(host_done), .host_rdata(host_rdata),
        .pin_stat(pin_stat), .upd_data_vld(upd_data_vld), .upd_data(upd_data),
        .upd_dir_vld(upd_dir_vld), .upd_dir(upd_dir), .upd_ctl_vld(upd_ctl_vld),
        .upd_ctl(upd_ctl), .epp_nwrite(epp_nwrite), .epp_astb_n(epp_astb_n),
        .epp_dstb_n(epp_dstb_n), .epp_dout(epp_dout), .epp_din(epp_din),
        .epp_wait(epp_wait)
    );

    function automatic logic [7:0] rd_byte(input int p);
        return 8'((p * 37 + 11) & 255);
    endfunction

    // peripheral model and monitors
    int rd_ptr = 0, resp_delay = 1, silent_at = 1 << 30, rcnt = 0;
    int n_data = 0, n_dir = 0, n_ctl = 0, log_n = 0, run = 0, last_run = 0;
    logic [7:0] last_data; logic last_dir; logic [4:0] last_ctl;
    bit prev_dir_vld = 0, ctl_after_dir = 0, prev_a = 1, prev_d = 1;
    bit log_adr [0:1023]; bit log_nw [0:1023]; logic [7:0] log_dout [0:1023];

    assign epp_din = rd_byte(rd_ptr);

    always @(posedge clk) begin
        if (!epp_astb_n || !epp_dstb_n) begin
            rcnt <= rcnt + 1;
            epp_wait <= (resp_delay != 0) && (rd_ptr < silent_at) && (rcnt + 1 >= resp_delay);
        end else begin
            rcnt <= 0;
            epp_wait <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (upd_data_vld) begin n_data++; last_data = upd_data; end
        if (upd_dir_vld)  begin n_dir++;  last_dir = upd_dir; end
        if (upd_ctl_vld)  begin n_ctl++;  last_ctl = upd_ctl; ctl_after_dir = prev_dir_vld; end
        prev_dir_vld = upd_dir_vld;
        if ((prev_a && !epp_astb_n) || (prev_d && !epp_dstb_n)) begin
            log_adr[log_n % 1024] = !epp_astb_n;
            log_nw[log_n % 1024] = epp_nwrite;
            log_dout[log_n % 1024] = epp_dout;
            log_n++;
        end
        if ((!prev_a && epp_astb_n) || (!prev_d && epp_dstb_n)) rd_ptr++;
        if (!epp_astb_n || !epp_dstb_n) run++;
        else if (run > 0) begin last_run = run; run = 0; end
        prev_a = epp_astb_n; prev_d = epp_dstb_n;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    bit busy_bad = 0;
    task automatic access(input bit wr, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_done) begin
            if (host_rdy) busy_bad = 1;
            @(negedge clk);
        end
        rd = host_rdata;
        @(negedge clk);
        if (host_done || !host_rdy) busy_bad = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, e;
        int n0, p0, nd, ndir;
        logic [7:0] ctl_model;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        access(0, 3'd2, 0, 0, r); chk(r == 32'hFFFF_FFCC, "R1 control reset", r, 32'hFFFF_FFCC);
        access(0, 3'd0, 0, 0, r); chk(r == 32'hFFFF_FFFF, "R1 data reset", r, 32'hFFFF_FFFF);
        access(0, 3'd1, 0, 0, r); chk(r == 32'hFFFF_FFAA, "R1 status reset", r, 32'hFFFF_FFAA);
        chk(log_n == 0, "R1 no strobe", log_n, 0);

        // R2 data latch write and suppression
        access(1, 3'd0, 0, 32'h3C, r);
        chk(n_data == 1 && last_data == 8'h3C, "R2 data pulse", {n_data[23:0], last_data}, 32'h13C);
        access(1, 3'd0, 0, 32'hFF3C, r);
        chk(n_data == 1, "R2 equal write suppressed", n_data, 1);
        access(0, 3'd0, 0, 0, r); chk(r == 32'hFFFF_FF3C, "R2 data readback", r, 32'hFFFF_FF3C);

        // R3 control sweep over bits 4:0
        ctl_model = 8'hCC;
        for (int v = 0; v < 32; v++) begin
            nd = n_ctl; ndir = n_dir;
            access(1, 3'd2, 0, v, r);
            e = ((8'(v) | 8'hC0) != ctl_model) ? 1 : 0;
            chk(n_ctl - nd == int'(e), "R3 control update count", n_ctl - nd, e);
            if (e != 0) chk(last_ctl == 5'(v), "R3 control pulse value", last_ctl, v);
            chk(n_dir == ndir, "R3 no direction pulse", n_dir, ndir);
            ctl_model = 8'(v) | 8'hC0;
            access(0, 3'd2, 0, 0, r);
            chk(r == {24'hFFFFFF, ctl_model}, "R3 control readback", r, {24'hFFFFFF, ctl_model});
        end

        // R4 direction change ordering
        ndir = n_dir; nd = n_ctl;
        access(1, 3'd2, 0, 32'h24, r);
        chk(n_dir == ndir + 1 && last_dir == 1'b1, "R4 direction pulse to input", last_dir, 1);
        chk(n_ctl == nd + 1 && ctl_after_dir && last_ctl == 5'h04, "R4 control after direction", last_ctl, 5'h04);
        access(0, 3'd2, 0, 0, r); chk(r == 32'hFFFF_FFE4, "R4 control readback", r, 32'hFFFF_FFE4);
        access(1, 3'd2, 0, 32'h04, r);
        chk(n_dir == ndir + 2 && last_dir == 1'b0 && ctl_after_dir, "R4 direction pulse to output", last_dir, 0);

        // R5 R8 write cycles, LSB first
        resp_delay = 1;
        n0 = log_n; access(1, 3'd3, 2, 32'hDEAD_BEA5, r);
        chk(log_n - n0 == 1 && log_adr[n0] && !log_nw[n0] && log_dout[n0] == 8'hA5,
            "R5 address write one byte", log_dout[n0], 8'hA5);
        n0 = log_n; access(1, 3'd4, 2, 32'h1122_3344, r);
        chk(log_n - n0 == 4, "R8 word write four bytes", log_n - n0, 4);
        for (int i = 0; i < 4; i++) begin
            e = (32'h1122_3344 >> (8 * i)) & 32'hFF;
            chk(!log_adr[n0+i] && !log_nw[n0+i] && log_dout[n0+i] == e[7:0], "R5 data write byte order", log_dout[n0+i], e);
        end
        n0 = log_n; access(1, 3'd4, 1, 32'hCAFE_BEEF, r);
        chk(log_n - n0 == 2 && log_dout[n0] == 8'hEF && log_dout[n0+1] == 8'hBE, "R8 half write", {log_dout[n0], log_dout[n0+1]}, 16'hEFBE);
        n0 = log_n; access(1, 3'd4, 3, 32'h0102_0304, r);
        chk(log_n - n0 == 4 && log_dout[n0+3] == 8'h01, "R8 size code 3 is word", log_n - n0, 4);

        // R11 strobe held until response
        for (int d = 1; d <= 3; d++) begin
            resp_delay = d;
            access(1, 3'd4, 0, 32'h77, r);
            chk(last_run == d + 1, "R11 strobe length follows response", last_run, d + 1);
        end
        resp_delay = 1;

        // R6 read cycles
        access(1, 3'd2, 0, 32'h24, r);
        n0 = log_n; p0 = rd_ptr; access(0, 3'd3, 2, 0, r);
        chk(r == {24'hFFFFFF, rd_byte(p0)} && log_adr[n0] && log_nw[n0], "R6 address read", r, {24'hFFFFFF, rd_byte(p0)});
        p0 = rd_ptr; access(0, 3'd4, 1, 0, r);
        e = {16'hFFFF, rd_byte(p0 + 1), rd_byte(p0)};
        chk(r == e, "R6 half read", r, e);
        p0 = rd_ptr; access(0, 3'd4, 2, 0, r);
        e = {rd_byte(p0 + 3), rd_byte(p0 + 2), rd_byte(p0 + 1), rd_byte(p0)};
        chk(r == e, "R8 word read LSB first", r, e);

        // R7 gate sweep over control bits 5:0
        for (int c = 0; c < 64; c++) begin
            access(1, 3'd2, 0, c, r);
            n0 = log_n; access(1, 3'd4, 0, 32'h5A, r);
            e = ((c & 8'h2F) == 8'h04) ? 1 : 0;
            chk(log_n - n0 == int'(e), "R7 write gate", log_n - n0, e);
            p0 = rd_ptr; access(0, 3'd4, 0, 0, r);
            e = ((c & 8'h2F) == 8'h24) ? {24'hFFFFFF, rd_byte(p0)} : 32'hFFFF_FFFF;
            chk(r == e, "R7 read gate", r, e);
        end
        access(1, 3'd2, 0, 32'h14, r);
        n0 = log_n; access(1, 3'd3, 0, 32'h66, r);
        chk(log_n - n0 == 1, "R7 interrupt-enable bit ignored", log_n - n0, 1);

        // R9 timeout on a write, rest abandoned
        access(1, 3'd2, 0, 32'h04, r);
        resp_delay = 0;
        n0 = log_n; access(1, 3'd4, 2, 32'hA1B2_C3D4, r);
        chk(log_n - n0 == 1, "R9 write abandoned after failure", log_n - n0, 1);
        chk(last_run == TMO, "R9 strobe length at limit", last_run, TMO);
        access(0, 3'd1, 0, 0, r); chk(r[0] == 1'b1, "R9 timeout flag set", r[0], 1);

        // R9 R8 partial read: third byte fails
        resp_delay = 1;
        access(1, 3'd2, 0, 32'h24, r);
        p0 = rd_ptr; silent_at = p0 + 2;
        n0 = log_n; access(0, 3'd4, 2, 0, r);
        e = {16'hFFFF, rd_byte(p0 + 1), rd_byte(p0)};
        chk(r == e && log_n - n0 == 3, "R9 partial read keeps ones", r, e);
        silent_at = 1 << 30;

        // R10 sticky flag and status layout
        access(1, 3'd4, 0, 0, r);
        access(0, 3'd1, 0, 0, r); chk(r[0] == 1'b1, "R10 flag survives good cycle", r[0], 1);
        access(1, 3'd1, 0, 32'hFE, r);
        access(0, 3'd1, 0, 0, r); chk(r[0] == 1'b1, "R10 bit0 zero keeps flag", r[0], 1);
        access(1, 3'd1, 0, 32'h01, r);
        pin_stat = 7'h2B;
        access(0, 3'd1, 0, 0, r); chk(r == 32'hFFFF_FF56, "R10 flag cleared and pins shown", r, 32'hFFFF_FF56);

        // R12 handshake with host
        chk(!busy_bad, "R12 ready and done discipline", busy_bad, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule